// File: doc/BRIEF.md
# Hierarchical Not-MRU Replacement Selector

This block holds the replacement state for every set of a set-associative cache and names a victim way on request. The ways of a set are cut into equal groups of consecutive ways. For each set the block remembers the group that was touched last and, separately for each group, the way inside that group that was touched last. It does not track a full recency order.

Each access, whether a hit or a fill, is presented as a one-cycle strobe with a set number and a way number. The record for that set is rewritten on the following clock edge. A separate query port takes a set number and that set's per-way valid vector. The victim for that set comes back combinationally from the stored record. The victim is chosen in this order:
- the lowest-numbered invalid way, if any way is invalid;
- otherwise, the lowest-numbered way of the lowest-numbered group that was not touched last, skipping that group's last-touched way.

Tag lookup, data storage and miss sequencing live elsewhere. The set count, the way count and the group count are parameters and must be powers of two. There must be at least two groups, and at least two ways in each group.

Top module: `hier_nmru_sel`

## Requirements
- R1: After a synchronous active-high reset, every set records group 0 as its last-used group and local way 0 as the last-used way of each group. With all ways valid, the victim of any set is therefore way WAYS_PER_GROUP+1, which is way 5 in the default 8-way, 2-group setup.
- R2: If any bit of `qry_valid` is 0, `victim_way` is the lowest-numbered way whose valid bit is 0, regardless of the stored state.
- R3: After an access to way w of a set, a query on that set with all ways valid returns a victim outside w's group.
- R4: With all ways valid, the victim sits in the lowest-numbered group other than the last-used group. Inside that group it is the lowest-numbered local way other than that group's last-used way.
- R5: An access presented with `acc_vld` high changes the state on the next rising edge, and not before. When `acc_vld` is low, `acc_set` and `acc_way` have no effect.
- R6: An access to one set does not change the victim reported for any other set.
- R7: `victim_way` is a combinational function of `qry_set`, `qry_valid` and the stored state. It follows a change of `qry_valid` within the same cycle.
- R8: Way w belongs to group w / WAYS_PER_GROUP, at local position w % WAYS_PER_GROUP. In the default setup, ways 0 to 3 form group 0 and ways 4 to 7 form group 1.
- R9: The last-used way of a group is kept while other groups are accessed. It is used again once that group becomes the victim group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe (hit or fill) |
| acc_set | input | SET_W | Set of the access |
| acc_way | input | WAY_W | Way of the access |
| qry_set | input | SET_W | Set whose victim is requested |
| qry_valid | input | NUM_WAYS | Per-way valid bits of the queried set |
| victim_way | output | WAY_W | Selected victim way |

## Verification
The victim is examined after access sequences that alternate between the two groups. Some sequences return to a group whose last-used way was recorded earlier, which separates a correct per-group record from one that is cleared or shared across groups. Valid vectors with one or several zero bits check that an invalid way takes priority over the stored state, and that the lowest-numbered invalid way is picked. Queries on a set other than the one accessed check that state is kept per set. Strobes held low, and queries made before the update edge, separate the correct update timing from early or unconditional writes.

// File: rtl/hnmru_pkg.sv
package hnmru_pkg;

    localparam int DEF_SETS   = 16;
    localparam int DEF_WAYS   = 8;
    localparam int DEF_GROUPS = 2;

    // Lowest index in [0, n) that differs from idx, for n >= 2.
    function automatic int lowest_other(input int idx);
        return (idx == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/hnmru_state_store.sv
module hnmru_state_store #(
    parameter int NUM_SETS   = 16,
    parameter int NUM_GROUPS = 2,
    parameter int WPG        = 4,
    localparam int SET_W     = $clog2(NUM_SETS),
    localparam int GRP_W     = $clog2(NUM_GROUPS),
    localparam int LW_W      = $clog2(WPG)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [SET_W-1:0]                 wr_set,
    input  logic [GRP_W-1:0]                 wr_grp,
    input  logic [LW_W-1:0]                  wr_lway,
    input  logic [SET_W-1:0]                 rd_set,
    output logic [GRP_W-1:0]                 rd_mru_grp,
    output logic [NUM_GROUPS-1:0][LW_W-1:0]  rd_mru_lway
);

    logic [GRP_W-1:0]                grp_q [NUM_SETS];
    logic [NUM_GROUPS-1:0][LW_W-1:0] lway_q [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                grp_q[s]  <= '0;
                lway_q[s] <= '0;
            end
        end else if (wr_en) begin
            grp_q[wr_set]          <= wr_grp;
            lway_q[wr_set][wr_grp] <= wr_lway;
        end
    end

    assign rd_mru_grp  = grp_q[rd_set];
    assign rd_mru_lway = lway_q[rd_set];

endmodule

// File: rtl/hnmru_inval_scan.sv
module hnmru_inval_scan #(
    parameter int NUM_WAYS = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] valid,
    output logic                any_inval,
    output logic [WAY_W-1:0]    first_inval
);

    always_comb begin
        any_inval   = ~&valid;
        first_inval = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) first_inval = WAY_W'(w);
        end
    end

endmodule

// File: rtl/hnmru_victim_pick.sv
module hnmru_victim_pick
    import hnmru_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int WPG        = 4,
    localparam int GRP_W     = $clog2(NUM_GROUPS),
    localparam int LW_W      = $clog2(WPG),
    localparam int WAY_W     = GRP_W + LW_W
) (
    input  logic [GRP_W-1:0]                mru_grp,
    input  logic [NUM_GROUPS-1:0][LW_W-1:0] mru_lway,
    output logic [WAY_W-1:0]                nmru_way
);

    logic [GRP_W-1:0] vic_grp;
    logic [LW_W-1:0]  vic_lway;

    generate
        if (NUM_GROUPS == 2) begin : g_two_groups
            assign vic_grp = ~mru_grp;
        end else begin : g_many_groups
            assign vic_grp = GRP_W'(lowest_other(int'(mru_grp)));
        end

        if (WPG == 2) begin : g_pair_ways
            assign vic_lway = ~mru_lway[vic_grp];
        end else begin : g_wide_ways
            assign vic_lway = LW_W'(lowest_other(int'(mru_lway[vic_grp])));
        end
    endgenerate

    assign nmru_way = {vic_grp, vic_lway};

endmodule

// File: rtl/hier_nmru_sel.sv
module hier_nmru_sel
    import hnmru_pkg::*;
#(
    parameter int NUM_SETS   = DEF_SETS,
    parameter int NUM_WAYS   = DEF_WAYS,
    parameter int NUM_GROUPS = DEF_GROUPS,
    localparam int WPG       = NUM_WAYS / NUM_GROUPS,
    localparam int SET_W     = $clog2(NUM_SETS),
    localparam int WAY_W     = $clog2(NUM_WAYS),
    localparam int GRP_W     = $clog2(NUM_GROUPS),
    localparam int LW_W      = $clog2(WPG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_vld,
    input  logic [SET_W-1:0]    acc_set,
    input  logic [WAY_W-1:0]    acc_way,
    input  logic [SET_W-1:0]    qry_set,
    input  logic [NUM_WAYS-1:0] qry_valid,
    output logic [WAY_W-1:0]    victim_way
);

    logic [GRP_W-1:0]                acc_grp;
    logic [LW_W-1:0]                 acc_lway;
    logic [GRP_W-1:0]                st_grp;
    logic [NUM_GROUPS-1:0][LW_W-1:0] st_lway;
    logic [WAY_W-1:0]                nmru_way;
    logic                            any_inval;
    logic [WAY_W-1:0]                first_inval;

    // Upper bits of the way number pick the group, lower bits the slot in it.
    assign acc_grp  = acc_way[WAY_W-1:LW_W];
    assign acc_lway = acc_way[LW_W-1:0];

    hnmru_state_store #(
        .NUM_SETS  (NUM_SETS),
        .NUM_GROUPS(NUM_GROUPS),
        .WPG       (WPG)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (acc_vld),
        .wr_set     (acc_set),
        .wr_grp     (acc_grp),
        .wr_lway    (acc_lway),
        .rd_set     (qry_set),
        .rd_mru_grp (st_grp),
        .rd_mru_lway(st_lway)
    );

    hnmru_victim_pick #(
        .NUM_GROUPS(NUM_GROUPS),
        .WPG       (WPG)
    ) u_pick (
        .mru_grp (st_grp),
        .mru_lway(st_lway),
        .nmru_way(nmru_way)
    );

    hnmru_inval_scan #(
        .NUM_WAYS(NUM_WAYS)
    ) u_scan (
        .valid      (qry_valid),
        .any_inval  (any_inval),
        .first_inval(first_inval)
    );

    assign victim_way = any_inval ? first_inval : nmru_way;

endmodule

// File: rtl/hnmru_chk.sv
module hnmru_chk #(
    parameter int NUM_SETS   = 16,
    parameter int NUM_WAYS   = 8,
    parameter int NUM_GROUPS = 2,
    localparam int WPG       = NUM_WAYS / NUM_GROUPS,
    localparam int SET_W     = $clog2(NUM_SETS),
    localparam int WAY_W     = $clog2(NUM_WAYS),
    localparam int LW_W      = $clog2(WPG)
) (
    input logic                clk,
    input logic                rst,
    input logic                acc_vld,
    input logic [SET_W-1:0]    acc_set,
    input logic [WAY_W-1:0]    acc_way,
    input logic [SET_W-1:0]    qry_set,
    input logic [NUM_WAYS-1:0] qry_valid,
    input logic [WAY_W-1:0]    victim_way
);

    logic [NUM_WAYS-1:0] below_mask;
    assign below_mask = (NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1);

    // R2
    inval_taken_chk: assert property (@(posedge clk) disable iff (rst)
        !(&qry_valid) |-> !qry_valid[victim_way]);

    // R2
    inval_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        !(&qry_valid) |-> ((qry_valid & below_mask) == below_mask));

    // R3
    grp_left_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(acc_vld) && (qry_set == $past(acc_set)) && (&qry_valid))
        |-> (victim_way[WAY_W-1:LW_W] != $past(acc_way[WAY_W-1:LW_W])));

    // R4
    not_last_way_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(acc_vld) && (qry_set == $past(acc_set)) && (&qry_valid))
        |-> (victim_way != $past(acc_way)));

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(acc_vld) && $stable(qry_set) && $stable(qry_valid))
        |-> $stable(victim_way));

endmodule

bind hier_nmru_sel hnmru_chk #(
    .NUM_SETS  (NUM_SETS),
    .NUM_WAYS  (NUM_WAYS),
    .NUM_GROUPS(NUM_GROUPS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_vld   (acc_vld),
    .acc_set   (acc_set),
    .acc_way   (acc_way),
    .qry_set   (qry_set),
    .qry_valid (qry_valid),
    .victim_way(victim_way)
);

// File: tb/hier_nmru_sel_test.sv
module hier_nmru_sel_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       acc_vld;
    logic [3:0] acc_set;
    logic [2:0] acc_way;
    logic [3:0] qry_set;
    logic [7:0] qry_valid;
    logic [2:0] victim_way;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hier_nmru_sel uut (
        .clk       (clk),
        .rst       (rst),
        .acc_vld   (acc_vld),
        .acc_set   (acc_set),
        .acc_way   (acc_way),
        .qry_set   (qry_set),
        .qry_valid (qry_valid),
        .victim_way(victim_way)
    );

    typedef struct packed {
        logic [3:0] aset;
        logic [2:0] away;
        logic [3:0] qset;
        logic [7:0] vld;
        logic [2:0] exp;
    } vec_t;

    // Each entry: one access strobe, then a query. Expected values follow
    // R3/R4/R8/R9 (groups: ways 0-3 and 4-7) and R2 for invalid ways.
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  3'd2, 4'd3,  8'hFF,        3'd5}, // R3 g0 used -> g1 slot1
        '{4'd3,  3'd5, 4'd3,  8'hFF,        3'd0}, // R4 g1 used -> g0 skip slot2
        '{4'd3,  3'd0, 4'd3,  8'hFF,        3'd4}, // R4 g1 last slot1 -> way4
        '{4'd3,  3'd7, 4'd3,  8'hFF,        3'd1}, // R8 way7 is g1
        '{4'd3,  3'd7, 4'd3,  8'b1110_1111, 3'd4}, // R2 single invalid
        '{4'd3,  3'd1, 4'd3,  8'b0111_1110, 3'd0}, // R2 several invalid
        '{4'd3,  3'd3, 4'd3,  8'hFF,        3'd4}, // R9 g1 kept slot3
        '{4'd9,  3'd4, 4'd9,  8'hFF,        3'd1}, // R3 other set
        '{4'd9,  3'd6, 4'd9,  8'h7F,        3'd7}, // R2 top way invalid
        '{4'd9,  3'd0, 4'd3,  8'hFF,        3'd4}, // R6 set3 untouched
        '{4'd9,  3'd1, 4'd9,  8'hFF,        3'd4}, // R9 g1 slot2 kept
        '{4'd15, 3'd3, 4'd0,  8'hFF,        3'd5}, // R6 set0 still reset
        '{4'd15, 3'd3, 4'd15, 8'hFF,        3'd5}, // R4 repeat access
        '{4'd0,  3'd5, 4'd0,  8'h00,        3'd0}  // R2 all invalid
    };

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: victim_way=%0d expected %0d", req, got, exp);
        end
    endtask

    task automatic access(input logic [3:0] s, input logic [2:0] w);
        @(negedge clk);
        acc_vld = 1'b1;
        acc_set = s;
        acc_way = w;
        @(negedge clk);
        acc_vld = 1'b0;
    endtask

    initial begin
        rst       = 1'b1;
        acc_vld   = 1'b0;
        acc_set   = '0;
        acc_way   = '0;
        qry_set   = '0;
        qry_valid = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state across several sets
        for (int s = 0; s < 16; s += 5) begin
            qry_set = 4'(s);
            #1 check("R1", victim_way, 3'd5);
        end

        // Vector table
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].aset, VECS[i].away);
            qry_set   = VECS[i].qset;
            qry_valid = VECS[i].vld;
            #1 check($sformatf("vector %0d", i), victim_way, VECS[i].exp);
        end

        // R5: set 3 is now g0 last / g0 slot3 / g1 slot3, victim 4.
        @(negedge clk);
        qry_set   = 4'd3;
        qry_valid = 8'hFF;
        acc_vld   = 1'b1;
        acc_set   = 4'd3;
        acc_way   = 3'd4;
        #1 check("R5 before edge", victim_way, 3'd4);
        @(negedge clk);
        acc_vld = 1'b0;
        #1 check("R5 after edge", victim_way, 3'd0);
        // R5: strobe low, access fields ignored
        acc_set = 4'd3;
        acc_way = 3'd0;
        repeat (2) @(negedge clk);
        #1 check("R5 strobe low", victim_way, 3'd0);

        // R7: valid change reflected in the same cycle
        qry_valid = 8'b1111_1011;
        #1 check("R7", victim_way, 3'd2);
        qry_valid = 8'hFF;
        #1 check("R7 restore", victim_way, 3'd0);

        // R1: reset clears updated sets
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        qry_set = 4'd3;
        #1 check("R1 re-reset set3", victim_way, 3'd5);
        qry_set = 4'd9;
        #1 check("R1 re-reset set9", victim_way, 3'd5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule